// File: doc/BRIEF.md
# Dual-Identity I2C Register Target

This block is an I2C target that listens for two 7-bit device identifiers on one bus. One identifier opens a control/status register bank. The other opens a user memory bank. Both banks sit behind a single 8-bit word pointer.

SCL and SDA are sampled on the system clock. The block finds START and STOP conditions, receives the slave byte and compares it with both identifiers. It then serves byte writes, current-address reads and random reads. A random read is a write phase that carries only a word address, then a repeated START, then a read phase. The block drives SDA only through an active-high pull-down enable, and the bus line itself is resistively pulled high outside the block.

Each bank holds one small array indexed by the low bits of the shared pointer. This lets the two spaces be written and read back independently.

Top module: `i2c_dual_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), the word pointer is 00h and every byte of both banks reads 00h, so a current-address read with no prior address returns the byte at location 00h.
- R2: A slave byte whose upper 7 bits are 1101111 selects the control/status bank, and one whose upper 7 bits are 1010111 selects the user bank. Bit 0 of the slave byte is the transfer direction (1 = read, 0 = write). The target pulls SDA low through the ninth clock of a matching slave byte.
- R3: A slave byte that matches neither identifier gets no acknowledge, and SDA stays released for every further clock until the next START.
- R4: A write transfer is slave byte with direction 0, one word-address byte, then data bytes. Each byte is acknowledged. Each data byte is stored in the selected bank at the entry given by the low 4 bits of the pointer (16 entries per bank).
- R5: A write to one bank leaves every byte of the other bank unchanged.
- R6: A random read returns the byte stored at the supplied word address in the bank named by the read-phase slave byte. The byte is shifted out most significant bit first.
- R7: During a read, the pointer advances by one after each byte sent and wraps from FFh to 00h, so a read crossing FFh continues at entry 0.
- R8: Every written data byte also advances the pointer. A current-address read starts where the last write or read left the pointer.
- R9: When a write-phase slave byte is followed by a repeated START and a read-phase slave byte with a different identifier, the second slave byte is not acknowledged. After a STOP, either identifier is accepted for a current-address read.
- R10: When the bus master answers a data byte with NACK, the target releases SDA and drives nothing more until the next START.
- R11: A STOP or START arriving in the middle of a byte abandons that byte. An address byte cut short this way leaves the pointer unchanged, and a new transfer after a mid-byte START is served normally.
- R12: The target never starts pulling SDA low while SCL is high. It pulls SDA low only during its acknowledge slots and for the 0 bits of read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench uses the default parameters: identifiers 1101111 and 1010111, 16 entries per bank and a two-stage input synchronizer. With 16 entries, the 8-bit pointer folds onto each bank many times. A four-byte read starting at FEh therefore exercises the FFh-to-00h wrap, and a write starting at FFh lands its second byte at entry 0. With two synchronizer stages, the bench's ten-clock quarter bit leaves enough margin to observe acknowledge timing and SDA changes that happen only while SCL is low.

// File: rtl/i2c_dual_pkg.sv
`timescale 1ns/1ps
package i2c_dual_pkg;
  // protocol phase of the target
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK_OUT,
    PH_TX,
    PH_ACK_IN
  } phase_t;

  // meaning of the byte currently being received
  typedef enum logic [1:0] {
    RB_DEV,
    RB_WADDR,
    RB_WDATA
  } rxbyte_t;

  localparam int unsigned NUM_BANKS = 2;
  localparam logic BANK_CSR  = 1'b0;
  localparam logic BANK_USER = 1'b1;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic [STAGES-1:0] scl_ff_d, sda_ff_d;
  logic scl_q, sda_q;
  logic scl_s;

  assign scl_ff_d = {scl_ff[STAGES-2:0], scl_i};
  assign sda_ff_d = {sda_ff[STAGES-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= scl_ff_d;
      sda_ff <= sda_ff_d;
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_comb begin
    scl_s     = scl_ff[STAGES-1];
    sda_s     = sda_ff[STAGES-1];
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_bank_store.sv
`timescale 1ns/1ps
module i2c_bank_store
  import i2c_dual_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 wbank,
  input  logic [AW-1:0]        widx,
  input  logic [7:0]           wdata,
  input  logic                 rbank,
  input  logic [AW-1:0]        ridx,
  output logic [7:0]           rdata,
  output logic [NUM_BANKS-1:0] bank_we
);
  logic [7:0] bank_rd [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [7:0] mem [DEPTH];

    assign bank_we[g] = we && (wbank == g[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (bank_we[g]) begin
        mem[widx] <= wdata;
      end
    end

    assign bank_rd[g] = mem[ridx];
  end

  assign rdata = bank_rd[rbank];
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
module i2c_target_fsm
  import i2c_dual_pkg::*;
#(
  parameter logic [6:0] ID_CSR  = 7'b1101111,
  parameter logic [6:0] ID_USER = 7'b1010111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rdata,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       ptr_load,
  output logic       mem_we,
  output logic       bank_sel,
  output logic [7:0] wdata,
  output logic       idle
);
  phase_t     phase_q, phase_d;
  rxbyte_t    kind_q, kind_d;
  logic [3:0] bitcnt_q, bitcnt_d;
  logic [7:0] sh_q, sh_d;
  logic       oe_q, oe_d;
  logic [7:0] ptr_q, ptr_d;
  logic       bank_q, bank_d;
  logic       rd_q, rd_d;
  logic       rspend_q, rspend_d;
  logic       mack_q, mack_d;

  logic [6:0] dev_id;
  logic       hit_csr, hit_user, dev_bank, dev_rd, id_ok;

  always_comb begin
    dev_id   = sh_q[7:1];
    dev_rd   = sh_q[0];
    hit_csr  = (dev_id == ID_CSR);
    hit_user = (dev_id == ID_USER);
    dev_bank = hit_user ? BANK_USER : BANK_CSR;
    id_ok    = (hit_csr || hit_user) &&
               !(dev_rd && rspend_q && (dev_bank != bank_q));
  end

  always_comb begin
    phase_d  = phase_q;
    kind_d   = kind_q;
    bitcnt_d = bitcnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    ptr_d    = ptr_q;
    bank_d   = bank_q;
    rd_d     = rd_q;
    rspend_d = rspend_q;
    mack_d   = mack_q;
    ptr_load = 1'b0;
    mem_we   = 1'b0;

    if (stop_det) begin
      phase_d  = PH_IDLE;
      oe_d     = 1'b0;
      rspend_d = 1'b0;
    end else if (start_det) begin
      phase_d  = PH_RX;
      kind_d   = RB_DEV;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else begin
      case (phase_q)
        PH_RX: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            sh_d     = {sh_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            case (kind_q)
              RB_DEV: begin
                if (id_ok) begin
                  oe_d     = 1'b1;
                  phase_d  = PH_ACK_OUT;
                  bank_d   = dev_bank;
                  rd_d     = dev_rd;
                  rspend_d = !dev_rd;
                end else begin
                  phase_d  = PH_IDLE;
                end
              end
              RB_WADDR: begin
                oe_d     = 1'b1;
                phase_d  = PH_ACK_OUT;
                ptr_d    = sh_q;
                ptr_load = 1'b1;
              end
              default: begin
                oe_d    = 1'b1;
                phase_d = PH_ACK_OUT;
                mem_we  = 1'b1;
                ptr_d   = ptr_q + 8'd1;
              end
            endcase
          end
        end
        PH_ACK_OUT: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (kind_q == RB_DEV && rd_q) begin
              sh_d    = rdata;
              oe_d    = ~rdata[7];
              ptr_d   = ptr_q + 8'd1;
              phase_d = PH_TX;
            end else begin
              oe_d    = 1'b0;
              phase_d = PH_RX;
              kind_d  = (kind_q == RB_DEV) ? RB_WADDR : RB_WDATA;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q != 4'd8) begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end else begin
              oe_d    = 1'b0;
              phase_d = PH_ACK_IN;
            end
          end
        end
        PH_ACK_IN: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            bitcnt_d = '0;
            if (mack_q) begin
              sh_d    = rdata;
              oe_d    = ~rdata[7];
              ptr_d   = ptr_q + 8'd1;
              phase_d = PH_TX;
            end else begin
              oe_d    = 1'b0;
              phase_d = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      kind_q   <= RB_DEV;
      bitcnt_q <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
      bank_q   <= BANK_CSR;
      rd_q     <= 1'b0;
      rspend_q <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      kind_q   <= kind_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      oe_q     <= oe_d;
      ptr_q    <= ptr_d;
      bank_q   <= bank_d;
      rd_q     <= rd_d;
      rspend_q <= rspend_d;
      mack_q   <= mack_d;
    end
  end

  assign sda_oe   = oe_q;
  assign ptr      = ptr_q;
  assign bank_sel = bank_q;
  assign wdata    = sh_q;
  assign idle     = (phase_q == PH_IDLE);
endmodule

// File: rtl/i2c_dual_target.sv
`timescale 1ns/1ps
module i2c_dual_target
  import i2c_dual_pkg::*;
#(
  parameter logic [6:0]  ID_CSR      = 7'b1101111,
  parameter logic [6:0]  ID_USER     = 7'b1010111,
  parameter int unsigned BANK_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int unsigned AW = $clog2(BANK_DEPTH);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rdata, ptr_q, wdata;
  logic ptr_load, mem_we, bank_sel, fsm_idle;
  logic [NUM_BANKS-1:0] bank_we;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_target_fsm #(.ID_CSR(ID_CSR), .ID_USER(ID_USER)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rdata     (rdata),
    .sda_oe    (sda_oe),
    .ptr       (ptr_q),
    .ptr_load  (ptr_load),
    .mem_we    (mem_we),
    .bank_sel  (bank_sel),
    .wdata     (wdata),
    .idle      (fsm_idle)
  );

  i2c_bank_store #(.DEPTH(BANK_DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we      (mem_we),
    .wbank   (bank_sel),
    .widx    (ptr_q[AW-1:0]),
    .wdata   (wdata),
    .rbank   (bank_sel),
    .ridx    (ptr_q[AW-1:0]),
    .rdata   (rdata),
    .bank_we (bank_we)
  );
endmodule

// File: rtl/i2c_dual_target_chk.sv
`timescale 1ns/1ps
module i2c_dual_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       idle,
  input logic [7:0] ptr,
  input logic       ptr_load,
  input logic       mem_we,
  input logic [1:0] bank_we
);
  // R1: the line is released while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_release_r1: assert (!sda_oe) else $error("sda_oe active in reset");
    end
  end

  // R12: no new pull-down begins while SCL has been high for a while
  p_oe_rise_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)) |-> !$rose(sda_oe));

  // R3, R10: an idle target never holds the line
  p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

  // R7: the pointer either steps by one (wrapping) or is loaded
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == ($past(ptr) + 8'd1)) || $past(ptr_load)));

  // R4: every stored byte is acknowledged on the bus
  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sda_oe);

  // R5: a write touches at most one bank
  p_one_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
endmodule

bind i2c_dual_target i2c_dual_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .idle     (fsm_idle),
  .ptr      (ptr_q),
  .ptr_load (ptr_load),
  .mem_we   (mem_we),
  .bank_we  (bank_we)
);

// File: tb/i2c_dual_target_test.sv
`timescale 1ns/1ps
module i2c_dual_target_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl_m, sda_m;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_dual_target uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  int tests = 0, fails = 0;
  int ref_mem [2][16];
  int ref_ptr = 0;
  bit quiet = 0;
  bit done = 0;
  int mon_rise_err = 0, mon_quiet_err = 0;
  int scl_hi = 0;
  logic prev_oe = 1'b0;

  // every-clock comparison of bus behaviour against the model's expectations
  always @(negedge clk) begin
    if (rst_n) begin
      scl_hi = scl_m ? scl_hi + 1 : 0;
      if (scl_hi > 4 && sda_oe && !prev_oe) mon_rise_err++;
      if (quiet && scl_m && sda_oe) mon_quiet_err++;
      prev_oe = sda_oe;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int dev(input int bank, input int rw);
    return ((bank != 0 ? 7'b1010111 : 7'b1101111) << 1) | rw;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bits(input int b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; quiet = 1; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    quiet = 0;
  endtask

  task automatic send_byte(input int b, output int ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = sda_bus ? 0 : 1;
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input int mack, output int b);
    sda_m = 1'b1;
    b = 0;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b = (b << 1) | int'(sda_bus);
      wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = mack ? 1'b0 : 1'b1; quiet = 1; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; quiet = 0; wq(2);
    sda_m = 1'b1;
  endtask

  task automatic wr(input int bank, input int addr, input int n,
                    input int d0, input int d1, input int d2, input string req);
    int a;
    int d;
    bus_start();
    send_byte(dev(bank, 0), a); chk({req, " slave ack"}, a, 1);
    send_byte(addr, a);         chk({req, " address ack"}, a, 1);
    ref_ptr = addr;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      send_byte(d, a); chk({req, " data ack"}, a, 1);
      ref_mem[bank][ref_ptr % 16] = d;
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic rd_body(input int bank, input int n, input string req);
    int b;
    for (int i = 0; i < n; i++) begin
      recv_byte((i < n - 1) ? 1 : 0, b);
      chk({req, " read data"}, b, ref_mem[bank][ref_ptr % 16]);
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic rd_cur(input int bank, input int n, input string req);
    int a;
    bus_start();
    send_byte(dev(bank, 1), a); chk({req, " read slave ack"}, a, 1);
    rd_body(bank, n, req);
  endtask

  task automatic rd_rand(input int bank, input int addr, input int n, input string req);
    int a;
    bus_start();
    send_byte(dev(bank, 0), a); chk({req, " dummy slave ack"}, a, 1);
    send_byte(addr, a);         chk({req, " address ack"}, a, 1);
    ref_ptr = addr;
    bus_start();
    send_byte(dev(bank, 1), a); chk({req, " read slave ack"}, a, 1);
    rd_body(bank, n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int a, b;
    for (int k = 0; k < 2; k++)
      for (int j = 0; j < 16; j++) ref_mem[k][j] = 0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    wq(5);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wq(10);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);

    // R1, R8: current-address read from the reset pointer
    rd_cur(0, 1, "R1");

    // R2, R4: byte writes into each bank at the same address
    wr(0, 8'h03, 1, 8'hA5, 0, 0, "R2 R4 csr");
    wr(1, 8'h03, 1, 8'h3C, 0, 0, "R2 R4 user");

    // R5, R6: random reads show the banks are separate
    rd_rand(0, 8'h03, 1, "R5");
    rd_rand(1, 8'h03, 1, "R6");

    // R4, R8: several data bytes advance the pointer, then read continues
    wr(1, 8'h0E, 3, 8'h11, 8'h22, 8'h33, "R4 multi");
    rd_cur(1, 2, "R8");

    // R7: sequential read across FFh -> 00h
    wr(0, 8'h00, 1, 8'h5A, 0, 0, "R7 prep");
    wr(0, 8'h0F, 1, 8'hF0, 0, 0, "R7 prep");
    wr(0, 8'h01, 1, 8'h12, 0, 0, "R7 prep");
    rd_rand(0, 8'hFE, 4, "R7");
    wr(1, 8'hFF, 2, 8'h81, 8'h82, 0, "R7 write wrap");
    rd_cur(1, 1, "R7 R8");

    // R3: unknown identifier never acknowledged
    bus_start();
    send_byte(8'hA0, a); chk("R3 unknown id ack", a, 0);
    send_byte(8'h00, a); chk("R3 following byte ack", a, 0);
    bus_stop();

    // R9: identity mismatch across a random read
    bus_start();
    send_byte(dev(0, 0), a); chk("R9 dummy slave ack", a, 1);
    send_byte(8'h05, a);     chk("R9 address ack", a, 1);
    ref_ptr = 5;
    bus_start();
    send_byte(dev(1, 1), a); chk("R9 mismatched read slave ack", a, 0);
    bus_stop();
    rd_cur(1, 1, "R9 after stop");

    // R10: master NACK silences the target
    bus_start();
    send_byte(dev(0, 1), a); chk("R10 slave ack", a, 1);
    recv_byte(0, b);
    chk("R10 data", b, ref_mem[0][ref_ptr % 16]);
    ref_ptr = (ref_ptr + 1) % 256;
    recv_byte(0, b); chk("R10 released after NACK", b, 8'hFF);
    bus_stop();

    // R11: STOP inside the address byte keeps the pointer
    bus_start();
    send_byte(dev(0, 0), a); chk("R11 slave ack", a, 1);
    send_bits(8'h40, 4);
    bus_stop();
    rd_cur(0, 1, "R11 pointer kept");

    // R11: START inside a byte restarts reception
    bus_start();
    send_bits(dev(0, 0), 3);
    wr(0, 8'h07, 1, 8'h77, 0, 0, "R11 after restart");
    rd_rand(0, 8'h07, 1, "R11 readback");

    // R12: per-clock bus monitor results
    chk("R12 pull-down began with SCL high", mon_rise_err, 0);
    chk("R12 drove while master owned SDA", mon_quiet_err, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule